// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC and stores incoming Ethernet frames into host memory through a ring of descriptors. Frame bytes arrive on a byte stream that marks the first and the last byte of each frame. Each descriptor points at a fixed-size buffer. A frame that does not fit in one buffer continues into the buffers of the following descriptors. When the block finishes with a buffer, it writes the descriptor back, sets the ownership bit and fills in a status word. Software reads the finished descriptors, copies the data out, and clears the ownership bit to hand each buffer back.

The descriptor memory has a 32-bit read port that returns the address word of an entry, and a 64-bit write port that writes a whole entry in one cycle. The address word is in bits 31:0 of the entry and the status word is in bits 63:32. Both ports are addressed at `ring_base + index`. Frame bytes go out on a byte-wide buffer write port. The block also gives a one-cycle pulse when a frame has been stored completely and a one-cycle pulse when a frame had to be cut short because no buffer was free. The descriptor for the next buffer is fetched ahead of need, so bytes may arrive on every cycle inside a frame. Between the last byte of one frame and the first byte of the next there must be at least three idle cycles. When stripping is on, frames must be at least five bytes long.

Top module: `rxr_ring_writer`

## Requirements
- R1: When a buffer is finished, its descriptor is written back with address-word bit 0 (ownership) set to 1, bit 1 (last-in-ring) unchanged, and bits 31:2 (word address of the buffer) unchanged.
- R2: The kept bytes of a frame are written in arrival order. They start at byte offset 0 of the first buffer and fill each buffer of BUF_BYTES (default 128) bytes before moving to the buffer of the next descriptor.
- R3: In the status word, bit 14 is set only in the buffer holding the first byte of the frame. Bit 15 is set only in the buffer holding the last kept byte. Bits 10:0 hold the total kept length in that last buffer and are zero in every other buffer. All other status bits are zero.
- R4: The descriptor after one whose bit 1 is set is entry 0 of the ring, at `ring_base`. Otherwise the next descriptor is the following entry.
- R5: With `strip_fcs` high, the final 4 bytes of a frame are neither stored nor counted in the length. With `strip_fcs` low, every byte is stored and counted.
- R6: If the descriptor needed for the next byte still has bit 0 set, the rest of the frame is discarded and `rx_bna` pulses for one cycle. Buffers already finished for that frame stay written with bit 15 clear, and no further buffer writes occur until the next frame start.
- R7: `rx_done` pulses for one cycle, in the same cycle as the descriptor write of the frame's last buffer, only for frames stored completely.
- R8: While `rx_en` is low, input bytes are ignored. After `rx_en` is raised again, the next buffer is taken from entry 0 of the ring.
- R9: Bytes presented outside a frame, meaning after an end marker and before the next start marker, produce no memory writes.
- R10: After reset, `buf_we`, `desc_we`, `rx_done` and `rx_bna` are low.
- R11: A descriptor that caused a discard is picked up again once software clears its bit 0, and later frames are stored starting from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| strip_fcs | input | 1 | Drop the final 4 bytes of every frame |
| ring_base | input | AW | Descriptor memory entry of ring index 0 |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| desc_re | output | 1 | Descriptor read strobe |
| desc_raddr | output | AW | Descriptor read entry |
| desc_rdata | input | 32 | Address word of the entry, one cycle after the strobe |
| desc_we | output | 1 | Descriptor write strobe |
| desc_waddr | output | AW | Descriptor write entry |
| desc_wdata | output | 64 | Status word in 63:32, address word in 31:0 |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rx_done | output | 1 | Frame stored completely |
| rx_bna | output | 1 | Frame cut short, no free buffer |

## Verification
The bench targets frames that end exactly on a buffer boundary and frames that run one byte past it. A design that gets these wrong either closes an empty extra buffer or leaves bit 15 off the last one. It also crosses the wrap entry inside a frame: a design that ignores bit 1 writes past the ring. With stripping on, it sends a frame whose kept part is exactly one buffer long, which catches a delay line that is off by one byte. It makes a frame run into a buffer that software still owns, then releases that buffer and sends again. This catches a design that overwrites the owned buffer, reports the cut frame as done, or stalls instead of polling. Toggling the enable and sending bytes between frames checks that the ring restarts at entry 0 and that stray bytes write nothing.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;
  localparam int LEN_W    = 11;
endpackage

// File: rtl/rxr_front.sv
module rxr_front #(
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       strip,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       s_valid,
  output logic [7:0] s_data,
  output logic       s_last,
  output logic       s_start
);
  localparam int CNT_W = $clog2(FCS_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FCS_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic                       active_q, active_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d, cnt_eff;
  logic [FCS_BYTES-1:0][7:0]  dl_q, dl_d;
  logic                       acc;

  always_comb begin
    acc     = in_valid && rx_en && (in_sof || active_q);
    cnt_eff = in_sof ? '0 : cnt_q;
    s_start = acc && in_sof;
    s_last  = acc && in_eof;
    s_valid = strip ? (acc && (cnt_eff == CNT_FULL)) : acc;
    s_data  = strip ? dl_q[FCS_BYTES-1] : in_data;
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    dl_d     = dl_q;
    if (!rx_en) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (acc) begin
      active_d = !in_eof;
      cnt_d    = (cnt_eff == CNT_FULL) ? CNT_FULL : cnt_eff + CNT_ONE;
      dl_d     = {dl_q[FCS_BYTES-2:0], in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dl_q     <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      dl_q     <= dl_d;
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_strip_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strip && acc && in_sof) |-> !s_valid);
endmodule

// File: rtl/rxr_fetch.sv
module rxr_fetch
  import rxr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [AW-1:0]     ring_base,
  input  logic              take,
  output logic              desc_re,
  output logic [AW-1:0]     desc_raddr,
  input  logic [WORD_W-1:0] desc_rdata,
  output logic              pf_ready,
  output logic [WORD_W-3:0] pf_addr,
  output logic              pf_wrap,
  output logic [AW-1:0]     pf_idx
);
  localparam logic [AW-1:0] IDX_ONE = AW'(1);

  logic              valid_q, valid_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [AW-1:0]     idx_q, idx_d;

  always_comb begin
    desc_re    = rx_en && !valid_q && !pend_q;
    desc_raddr = ring_base + idx_q;
    pf_ready   = valid_q && !word_q[OWN_BIT];
    pf_addr    = word_q[WORD_W-1:2];
    pf_wrap    = word_q[WRAP_BIT];
    pf_idx     = idx_q;
  end

  always_comb begin
    valid_d = valid_q;
    pend_d  = pend_q;
    word_d  = word_q;
    idx_d   = idx_q;
    if (!rx_en) begin
      valid_d = 1'b0;
      pend_d  = 1'b0;
      idx_d   = '0;
    end else begin
      pend_d = desc_re;
      if (pend_q) begin
        word_d  = desc_rdata;
        valid_d = 1'b1;
      end
      if (take) begin
        valid_d = 1'b0;
        idx_d   = word_q[WRAP_BIT] ? '0 : idx_q + IDX_ONE;
      end else if (valid_q && word_q[OWN_BIT]) begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      word_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      word_q  <= word_d;
      idx_q   <= idx_d;
    end
  end

  p_take_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (valid_q && !word_q[OWN_BIT]));
  p_wrap_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && take && pf_wrap) |=> (idx_q == '0));
  p_disable_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!valid_q && idx_q == '0));
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BUF_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [AW-1:0]     ring_base,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              s_start,
  input  logic              pf_ready,
  input  logic [WORD_W-3:0] pf_addr,
  input  logic              pf_wrap,
  input  logic [AW-1:0]     pf_idx,
  output logic              take,
  output logic              buf_we,
  output logic [WORD_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              desc_we,
  output logic [AW-1:0]     desc_waddr,
  output logic [2*WORD_W-1:0] desc_wdata,
  output logic              rx_done,
  output logic              rx_bna
);
  localparam int FILL_W = $clog2(BUF_BYTES + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(BUF_BYTES);
  localparam logic [FILL_W-1:0] FILL_ONE  = FILL_W'(1);
  localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);

  logic [FILL_W-1:0] fill_q, fill_d, off, fill_nx;
  logic [LEN_W-1:0]  len_q, len_d, len_nx;
  logic [WORD_W-3:0] cur_addr_q, cur_addr_d, base_sel;
  logic [AW-1:0]     cur_idx_q, cur_idx_d, idx_sel;
  logic              cur_wrap_q, cur_wrap_d, wrap_sel;
  logic              cur_sof_q, cur_sof_d, sof_sel;
  logic              fresh_q, fresh_d, drop_q, drop_d;
  logic              is_first, drop_eff, need_buf, lose, store, close;
  logic [WORD_W-1:0] status;

  logic              buf_we_d, desc_we_d, done_d, bna_d;
  logic [WORD_W-1:0] buf_addr_d;
  logic [AW-1:0]     desc_waddr_d;
  logic [2*WORD_W-1:0] desc_wdata_d;

  always_comb begin
    is_first = fresh_q || s_start;
    drop_eff = drop_q && !s_start;
    need_buf = is_first || (fill_q == FILL_FULL);
    take     = s_valid && !drop_eff && need_buf && pf_ready;
    lose     = s_valid && !drop_eff && need_buf && !pf_ready;
    store    = s_valid && !drop_eff && !lose;
    base_sel = take ? pf_addr : cur_addr_q;
    idx_sel  = take ? pf_idx  : cur_idx_q;
    wrap_sel = take ? pf_wrap : cur_wrap_q;
    sof_sel  = take ? is_first : cur_sof_q;
    off      = need_buf ? '0 : fill_q;
    fill_nx  = off + FILL_ONE;
    len_nx   = is_first ? LEN_ONE : len_q + LEN_ONE;
    close    = store && ((fill_nx == FILL_FULL) || s_last);
    status   = '0;
    status[SOF_BIT] = sof_sel;
    if (s_last) begin
      status[EOF_BIT]     = 1'b1;
      status[LEN_W-1:0]   = len_nx;
    end
  end

  always_comb begin
    fill_d     = store ? fill_nx : fill_q;
    len_d      = store ? len_nx  : len_q;
    cur_addr_d = take ? pf_addr : cur_addr_q;
    cur_idx_d  = take ? pf_idx  : cur_idx_q;
    cur_wrap_d = take ? pf_wrap : cur_wrap_q;
    cur_sof_d  = take ? is_first : cur_sof_q;
    fresh_d    = fresh_q || s_start;
    if (s_valid && !drop_eff) fresh_d = 1'b0;
    drop_d     = s_start ? 1'b0 : drop_q;
    if (lose) drop_d = 1'b1;
    if (!rx_en) begin
      fresh_d = 1'b0;
      drop_d  = 1'b0;
    end
    buf_we_d     = store;
    buf_addr_d   = {base_sel, 2'b00} + WORD_W'(off);
    desc_we_d    = close;
    desc_waddr_d = ring_base + idx_sel;
    desc_wdata_d = {status, base_sel, wrap_sel, 1'b1};
    done_d       = close && s_last;
    bna_d        = lose;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      len_q      <= '0;
      cur_addr_q <= '0;
      cur_idx_q  <= '0;
      cur_wrap_q <= 1'b0;
      cur_sof_q  <= 1'b0;
      fresh_q    <= 1'b0;
      drop_q     <= 1'b0;
      buf_we     <= 1'b0;
      buf_addr   <= '0;
      buf_wdata  <= '0;
      desc_we    <= 1'b0;
      desc_waddr <= '0;
      desc_wdata <= '0;
      rx_done    <= 1'b0;
      rx_bna     <= 1'b0;
    end else begin
      fill_q     <= fill_d;
      len_q      <= len_d;
      cur_addr_q <= cur_addr_d;
      cur_idx_q  <= cur_idx_d;
      cur_wrap_q <= cur_wrap_d;
      cur_sof_q  <= cur_sof_d;
      fresh_q    <= fresh_d;
      drop_q     <= drop_d;
      buf_we     <= buf_we_d;
      desc_we    <= desc_we_d;
      rx_done    <= done_d;
      rx_bna     <= bna_d;
      if (buf_we_d) begin
        buf_addr  <= buf_addr_d;
        buf_wdata <= s_data;
      end
      if (desc_we_d) begin
        desc_waddr <= desc_waddr_d;
        desc_wdata <= desc_wdata_d;
      end
    end
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_FULL);
  p_own_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> desc_wdata[OWN_BIT]);
  p_len_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && !desc_wdata[WORD_W+EOF_BIT]) |-> (desc_wdata[WORD_W+LEN_W-1:WORD_W] == '0));
  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && s_valid && !s_start) |=> !buf_we);
  p_done_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (desc_we && desc_wdata[WORD_W+EOF_BIT]));
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BUF_BYTES = 128,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              strip_fcs,
  input  logic [AW-1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              desc_re,
  output logic [AW-1:0]     desc_raddr,
  input  logic [31:0]       desc_rdata,
  output logic              desc_we,
  output logic [AW-1:0]     desc_waddr,
  output logic [63:0]       desc_wdata,
  output logic              buf_we,
  output logic [31:0]       buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              rx_done,
  output logic              rx_bna
);
  logic              s_valid, s_last, s_start, take, pf_ready, pf_wrap;
  logic [7:0]        s_data;
  logic [WORD_W-3:0] pf_addr;
  logic [AW-1:0]     pf_idx;

  rxr_front #(.FCS_BYTES(FCS_BYTES)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .strip(strip_fcs),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_start(s_start)
  );

  rxr_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base), .take(take),
    .desc_re(desc_re), .desc_raddr(desc_raddr), .desc_rdata(desc_rdata),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_wrap(pf_wrap), .pf_idx(pf_idx)
  );

  rxr_writer #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_start(s_start),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_wrap(pf_wrap), .pf_idx(pf_idx),
    .take(take), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .rx_done(rx_done), .rx_bna(rx_bna)
  );
endmodule

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
  localparam int AW = 8;
  localparam int BUF = 128;
  localparam int NDESC = 4;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, strip_fcs = 1'b0;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic desc_re, desc_we, buf_we, rx_done, rx_bna;
  logic [AW-1:0] desc_raddr, desc_waddr;
  logic [31:0] desc_rdata, buf_addr;
  logic [63:0] desc_wdata;
  logic [7:0] buf_wdata;

  always #4 clk = ~clk;

  rxr_ring_writer u_rxr_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .strip_fcs(strip_fcs), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .desc_re(desc_re), .desc_raddr(desc_raddr), .desc_rdata(desc_rdata),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rx_done(rx_done), .rx_bna(rx_bna)
  );

  logic [63:0] dmem [0:255];
  logic [7:0]  bmem [0:1023];
  logic [7:0]  fr   [0:511];
  int done_cnt = 0, bna_cnt = 0, bw_cnt = 0;
  int total = 0, bad = 0, nidx = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (desc_re) desc_rdata <= dmem[desc_raddr][31:0];
    if (desc_we) dmem[desc_waddr] <= desc_wdata;
    if (buf_we) bmem[buf_addr[9:0]] <= buf_wdata;
    if (rx_done) done_cnt <= done_cnt + 1;
    if (rx_bna) bna_cnt <= bna_cnt + 1;
    if (buf_we) bw_cnt <= bw_cnt + 1;
  end

  function automatic logic [31:0] baddr(int k);
    return 32'h80 * (k + 1);
  endfunction

  function automatic logic [31:0] exp_addr_word(int k);
    return baddr(k) | ((k == NDESC - 1) ? 32'h2 : 32'h0) | 32'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic init_ring();
    for (int k = 0; k < NDESC; k++)
      dmem[BASE + k] = {32'h0, baddr(k) | ((k == NDESC - 1) ? 32'h2 : 32'h0)};
  endtask

  task automatic release_all();
    for (int k = 0; k < NDESC; k++) dmem[BASE + k][0] = 1'b0;
  endtask

  task automatic fill_frame(int n);
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom_range(255, 0));
  endtask

  task automatic send(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && $urandom_range(7, 0) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Check a stored frame of 'stored' kept bytes starting at ring index nidx.
  task automatic check_frame(int stored, bit rel, string req);
    int nb = (stored + BUF - 1) / BUF;
    for (int j = 0; j < nb; j++) begin
      int k = (nidx + j) % NDESC;
      int cnt = (j == nb - 1) ? stored - j * BUF : BUF;
      logic [31:0] exps;
      int mism = 0;
      exps = ((j == 0) ? 32'h4000 : 32'h0) | ((j == nb - 1) ? (32'h8000 | 32'(stored)) : 32'h0);
      chk(dmem[BASE + k][31:0] == exp_addr_word(k), "R1", "address word",
          dmem[BASE + k][31:0], exp_addr_word(k));
      chk(dmem[BASE + k][63:32] == exps, "R3", "status word", dmem[BASE + k][63:32], exps);
      for (int b = 0; b < cnt; b++)
        if (bmem[baddr(k) + b] !== fr[j * BUF + b]) mism++;
      chk(mism == 0, req, "buffer byte mismatches", mism, 0);
      if (rel) dmem[BASE + k][0] = 1'b0;
    end
    nidx = (nidx + nb) % NDESC;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int d0, b0, w0, n;
    bit s;
    logic [7:0] saved;
    void'($urandom(32'd77));
    init_ring();
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!buf_we && !desc_we && !rx_done && !rx_bna, "R10", "outputs after reset",
        {buf_we, desc_we, rx_done, rx_bna}, 0);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R2/R3/R7 single short frame
    fill_frame(60); d0 = done_cnt; send(60, 0);
    check_frame(60, 1, "R2");
    chk(done_cnt == d0 + 1, "R7", "done pulses", done_cnt - d0, 1);
    // exact buffer length
    fill_frame(128); send(128, 0); check_frame(128, 1, "R2");
    // one past a buffer, crossing the wrap entry (R4)
    fill_frame(129); send(129, 0); check_frame(129, 1, "R4");
    fill_frame(200); send(200, 0); check_frame(200, 1, "R4");
    // R5 strip: kept part exactly one buffer, then two buffers
    strip_fcs = 1'b1;
    fill_frame(132); send(132, 0); check_frame(128, 1, "R5");
    fill_frame(150); send(150, 0); check_frame(146, 1, "R5");
    strip_fcs = 1'b0;

    // R9 bytes outside a frame
    w0 = bw_cnt;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(i);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(bw_cnt == w0, "R9", "writes from stray bytes", bw_cnt - w0, 0);

    // R6 ring runs into an owned descriptor
    fill_frame(300); send(300, 0); check_frame(300, 0, "R2");  // idx1..3 kept owned
    saved = bmem[baddr(1)];
    d0 = done_cnt; b0 = bna_cnt;
    fill_frame(200); send(200, 0);
    chk(dmem[BASE + 0] == {32'h4000, exp_addr_word(0)}, "R6", "partial descriptor",
        dmem[BASE + 0], {32'h4000, exp_addr_word(0)});
    chk(bna_cnt == b0 + 1, "R6", "bna pulses", bna_cnt - b0, 1);
    chk(done_cnt == d0, "R7", "done for cut frame", done_cnt - d0, 0);
    chk(bmem[baddr(1)] == saved, "R6", "owned buffer untouched", bmem[baddr(1)], saved);
    // R11 release and continue from the blocked entry
    release_all(); nidx = 1;
    repeat (6) @(negedge clk);
    fill_frame(100); send(100, 0); check_frame(100, 1, "R11");

    // R8 disable, ignored input, restart at entry 0
    fill_frame(40); send(40, 0); check_frame(40, 1, "R2");
    rx_en = 1'b0;
    w0 = bw_cnt; d0 = done_cnt;
    fill_frame(30); send(30, 0);
    chk(bw_cnt == w0 && done_cnt == d0, "R8", "writes while disabled", bw_cnt - w0, 0);
    rx_en = 1'b1; nidx = 0;
    repeat (6) @(negedge clk);
    fill_frame(50); send(50, 0); check_frame(50, 1, "R8");

    // random frames
    for (int f = 0; f < 20; f++) begin
      n = $urandom_range(450, 5);
      s = 1'($urandom_range(1, 0));
      strip_fcs = s;
      d0 = done_cnt;
      fill_frame(n); send(n, 1);
      check_frame(s ? n - 4 : n, 1, s ? "R5" : "R2");
      chk(done_cnt == d0 + 1, "R7", "done pulses random", done_cnt - d0, 1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule